// File: doc/BRIEF.md
# Isochronous Cycle Timer

This block holds the bus time reference of a serial-bus link as one 32-bit word made of three chained counters. The low counter advances once per 24.576 MHz clock and wraps every 125 µs. Each of its wraps advances a cycle counter, and each wrap of the cycle counter advances a seconds counter. Together they give a local clock that steps once every bus cycle.

In the cycle-master role, the current word is the value placed in each outgoing cycle-start message. The block also raises a one-clock request at every cycle boundary so that the packet logic knows when to send that message. In any other role, the word is overwritten by the payload of each received cycle-start message and runs freely between messages. Free running only happens while the timer enable is set. Software can also load the whole word directly through a write port. Building and parsing packets is handled outside this block.

Top module: `cycle_timer`

## Requirements
- R1: During and directly after reset, `time_q` is 0 and `cs_req` is 0.
- R2: With `tmr_en` high and no load, the offset field (`time_q[11:0]`) increases by one every clock. When the offset is 3071 or higher, the next value is 0.
- R3: The cycle-count field (`time_q[24:12]`) increases by one in the same clock that the offset wraps to 0. When the cycle count is 7999 or higher, it becomes 0 at that point instead.
- R4: The seconds field (`time_q[31:25]`) increases by one in the same clock that the cycle count wraps to 0. From 127 it becomes 0.
- R5: With `tmr_en` low and no load, `time_q` holds its value and `cs_req` stays 0.
- R6: When `is_master` is low, a clock with `rx_cs_valid` high makes `time_q` equal `rx_cs_data` after that clock. This load takes precedence over counting and happens whether `tmr_en` is high or low.
- R7: When `is_master` is high, `rx_cs_valid` has no effect: the word keeps counting (or holding) as if no message had arrived.
- R8: A clock with `sw_wr` high makes `time_q` equal `sw_wdata` after that clock. This write takes precedence over a received-message load and over counting.
- R9: When `is_master` and `tmr_en` are both high, `cs_req` is high for exactly the one clock in which `time_q` first shows offset 0 after a wrap from 3071. At all other times it is 0, and it is never raised when the block is not cycle master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Enables free-running advance |
| is_master | input | 1 | High when this node is cycle master |
| rx_cs_valid | input | 1 | Strobe: a cycle-start message was received |
| rx_cs_data | input | 32 | Time payload of the received message |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write value |
| time_q | output | 32 | Current time word {seconds, cycle count, offset} |
| cs_req | output | 1 | One-clock request to send a cycle start |

## Verification
A load and an increment can compete in the same clock. A received-message load can collide with the carry ripple, and a software write can collide with a received message. The bench provokes both cases. It places the word one step before a full three-field wrap and asserts `rx_cs_valid` in that clock, and it raises `sw_wr` together with `rx_cs_valid`. It judges the outcome by requiring the loaded value exactly, with no trace of the increment. The boundary request is checked against counter wraps in both roles.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;
  localparam int OFS_W_DEF   = 12;
  localparam int CNT_W_DEF   = 13;
  localparam int SEC_W_DEF   = 7;
  localparam int OFS_MOD_DEF = 3072;
  localparam int CNT_MOD_DEF = 8000;
  localparam int SEC_MOD_DEF = 128;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_RUN  = 2'd1,
    SRC_RX   = 2'd2,
    SRC_SW   = 2'd3
  } time_src_e;

  function automatic time_src_e pick_src(input logic sw_wr, input logic rx_v,
                                         input logic master, input logic en);
    if (sw_wr)              return SRC_SW;
    else if (rx_v && !master) return SRC_RX;
    else if (en)            return SRC_RUN;
    else                    return SRC_HOLD;
  endfunction
endpackage

// File: rtl/cycle_timer_stage.sv
module cycle_timer_stage #(
  parameter int W   = 12,
  parameter int MOD = 3072
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  function automatic logic [W-1:0] f_adv(input logic [W-1:0] v);
    return (v >= LAST) ? '0 : v + 1'b1;
  endfunction

  assign carry = step && (cnt >= LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (step)  cnt <= f_adv(cnt);
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt < LAST) |=> cnt == $past(cnt) + 1'b1);
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !load) |=> cnt == '0);
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt));
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cycle_timer_pkg::*;
#(
  parameter int OFS_W   = OFS_W_DEF,
  parameter int CNT_W   = CNT_W_DEF,
  parameter int SEC_W   = SEC_W_DEF,
  parameter int OFS_MOD = OFS_MOD_DEF,
  parameter int CNT_MOD = CNT_MOD_DEF,
  parameter int SEC_MOD = SEC_MOD_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tmr_en,
  input  logic                         is_master,
  input  logic                         rx_cs_valid,
  input  logic [OFS_W+CNT_W+SEC_W-1:0] rx_cs_data,
  input  logic                         sw_wr,
  input  logic [OFS_W+CNT_W+SEC_W-1:0] sw_wdata,
  output logic [OFS_W+CNT_W+SEC_W-1:0] time_q,
  output logic                         cs_req
);
  localparam int TW      = OFS_W + CNT_W + SEC_W;
  localparam int CNT_LSB = OFS_W;
  localparam int SEC_LSB = OFS_W + CNT_W;

  time_src_e        src;
  logic             any_load;
  logic [TW-1:0]    load_word;
  logic             run_step;
  logic [OFS_W-1:0] ofs;
  logic [CNT_W-1:0] cyc;
  logic [SEC_W-1:0] sec;
  logic             ofs_carry, cyc_carry, sec_carry;
  logic             boundary;

  assign src       = pick_src(sw_wr, rx_cs_valid, is_master, tmr_en);
  assign any_load  = (src == SRC_SW) || (src == SRC_RX);
  assign load_word = (src == SRC_SW) ? sw_wdata : rx_cs_data;
  assign run_step  = (src == SRC_RUN);

  cycle_timer_stage #(.W(OFS_W), .MOD(OFS_MOD)) u_ofs (
    .clk(clk), .rst_n(rst_n), .load(any_load),
    .load_val(load_word[OFS_W-1:0]), .step(run_step),
    .cnt(ofs), .carry(ofs_carry));

  cycle_timer_stage #(.W(CNT_W), .MOD(CNT_MOD)) u_cyc (
    .clk(clk), .rst_n(rst_n), .load(any_load),
    .load_val(load_word[SEC_LSB-1:CNT_LSB]), .step(ofs_carry),
    .cnt(cyc), .carry(cyc_carry));

  cycle_timer_stage #(.W(SEC_W), .MOD(SEC_MOD)) u_sec (
    .clk(clk), .rst_n(rst_n), .load(any_load),
    .load_val(load_word[TW-1:SEC_LSB]), .step(cyc_carry),
    .cnt(sec), .carry(sec_carry));

  assign time_q   = {sec, cyc, ofs};
  assign boundary = is_master && ofs_carry;

  always_ff @(posedge clk) begin
    if (!rst_n) cs_req <= 1'b0;
    else        cs_req <= boundary;
  end

  p_sw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> time_q == $past(sw_wdata));
  p_rx_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cs_valid && !is_master && !sw_wr) |=> time_q == $past(rx_cs_data));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !sw_wr && !(rx_cs_valid && !is_master)) |=> ($stable(time_q) && !cs_req));
  p_req_role_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> !cs_req);
  p_req_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |-> time_q[OFS_W-1:0] == '0);
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |=> !cs_req);
  p_sec_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_carry && !any_load) |=> time_q == '0);
endmodule

// File: tb/cycle_timer_bench.sv
module cycle_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_en = 1'b0, is_master = 1'b0, rx_cs_valid = 1'b0, sw_wr = 1'b0;
  logic [31:0] rx_cs_data = '0, sw_wdata = '0;
  logic [31:0] time_q;
  logic        cs_req;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cycle_timer u_cycle_timer (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .is_master(is_master),
    .rx_cs_valid(rx_cs_valid), .rx_cs_data(rx_cs_data), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .time_q(time_q), .cs_req(cs_req));

  function automatic logic [31:0] pk(input int s, input int c, input int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] v);
    sw_wr = 1'b1; sw_wdata = v; tick(1); sw_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 time", time_q, 32'h0);
    chk("R1 req", {31'b0, cs_req}, 32'h0);
  endtask

  task automatic t_offset;
    tmr_en = 1'b1; tick(10);
    chk("R2 count up", time_q, pk(0, 0, 10));
    tmr_en = 1'b0;
    wr(pk(0, 0, 3070)); tmr_en = 1'b1; tick(1);
    chk("R2 at 3071", time_q, pk(0, 0, 3071));
    tick(1);
    chk("R2 R3 wrap", time_q, pk(0, 1, 0));
    tmr_en = 1'b0;
    wr(pk(0, 0, 4000)); tmr_en = 1'b1; tick(1);
    chk("R2 above last", time_q, pk(0, 1, 0));
    tmr_en = 1'b0;
  endtask

  task automatic t_count_sec;
    wr(pk(5, 7999, 3071)); tmr_en = 1'b1; tick(1);
    chk("R3 R4 count wrap", time_q, pk(6, 0, 0));
    tmr_en = 1'b0;
    wr(pk(127, 7999, 3071)); tmr_en = 1'b1; tick(1);
    chk("R4 full wrap", time_q, 32'h0);
    tmr_en = 1'b0;
  endtask

  task automatic t_disable;
    is_master = 1'b1;
    wr(pk(3, 20, 3071)); tick(5);
    chk("R5 hold", time_q, pk(3, 20, 3071));
    chk("R5 no req", {31'b0, cs_req}, 32'h0);
    is_master = 1'b0;
  endtask

  task automatic t_rx;
    wr(pk(127, 7999, 3071)); tmr_en = 1'b1;
    rx_cs_valid = 1'b1; rx_cs_data = 32'hA5A5_0123; tick(1);
    rx_cs_valid = 1'b0;
    chk("R6 load beats wrap", time_q, 32'hA5A5_0123);
    tick(1);
    chk("R6 runs after load", time_q, 32'hA5A5_0124);
    tmr_en = 1'b0;
    rx_cs_valid = 1'b1; rx_cs_data = pk(9, 100, 7); tick(1);
    rx_cs_valid = 1'b0; tick(2);
    chk("R6 load while disabled", time_q, pk(9, 100, 7));
  endtask

  task automatic t_rx_master;
    is_master = 1'b1;
    wr(pk(1, 2, 3)); tmr_en = 1'b1;
    rx_cs_valid = 1'b1; rx_cs_data = 32'hFFFF_0000; tick(1);
    rx_cs_valid = 1'b0;
    chk("R7 ignored when master", time_q, pk(1, 2, 4));
    tmr_en = 1'b0;
    rx_cs_valid = 1'b1; tick(1); rx_cs_valid = 1'b0;
    chk("R7 ignored while held", time_q, pk(1, 2, 4));
    is_master = 1'b0;
  endtask

  task automatic t_sw_prio;
    tmr_en = 1'b1;
    rx_cs_valid = 1'b1; rx_cs_data = 32'h1111_1111;
    sw_wr = 1'b1; sw_wdata = 32'h2222_2222; tick(1);
    rx_cs_valid = 1'b0; sw_wr = 1'b0;
    chk("R8 write beats rx and count", time_q, 32'h2222_2222);
    tmr_en = 1'b0;
  endtask

  task automatic t_req;
    int pulses;
    is_master = 1'b1;
    wr(pk(0, 0, 3069)); tmr_en = 1'b1; tick(1);
    chk("R9 none at 3070", {31'b0, cs_req}, 32'h0);
    tick(1);
    chk("R9 none at 3071", {31'b0, cs_req}, 32'h0);
    tick(1);
    chk("R9 pulse at wrap", {31'b0, cs_req}, 32'h1);
    chk("R9 value sent", time_q, pk(0, 1, 0));
    tick(1);
    chk("R9 one clock", {31'b0, cs_req}, 32'h0);
    tmr_en = 1'b0;
    wr(32'h0); tmr_en = 1'b1;
    pulses = 0;
    for (int i = 0; i < 3 * 3072; i++) begin
      tick(1);
      if (cs_req) pulses++;
    end
    chk("R9 pulse count", 32'(pulses), 32'd3);
    chk("R2 R3 long run", time_q, pk(0, 3, 0));
    is_master = 1'b0;
    tmr_en = 1'b0;
    wr(pk(0, 0, 3070)); tmr_en = 1'b1; tick(2);
    chk("R9 none when not master", {31'b0, cs_req}, 32'h0);
    tmr_en = 1'b0;
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1; tick(1);
    t_reset();
    t_offset();
    t_count_sec();
    t_disable();
    t_rx();
    t_rx_master();
    t_sw_prio();
    t_req();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule